// File: doc/BRIEF.md
# Framed Text Checksum Verifier

This block sits on a byte stream that carries a text transmission for a device programmer. It hunts for a start-of-text code, then adds every character code into a 16-bit running sum until the end-of-text code arrives. The start and end codes are part of the sum, and so are carriage returns and line feeds. Right after the end code come four ASCII hexadecimal characters that hold the sender's expected sum, most significant digit first. The block compares them with its own sum and reports the result with a one-cycle done pulse.

Every character between the two framing codes is also passed on, one cycle later, to the field parsers downstream. Codes outside the legal set raise a one-cycle illegal flag. A second start code inside an open frame raises a protocol flag and restarts the sum.

The controller has three states. `S_HUNT` waits for a start code and drops everything else. `S_BODY` sums and forwards characters. `S_DIGITS` collects the four check digits. The transitions are: HUNT to BODY on a start code; BODY to BODY on a repeated start code (restart); BODY to DIGITS on an end code; DIGITS to HUNT on the fourth hex digit or on any character that is not a hex digit.

Top module: `frame_sum_checker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, done, match, fmt_err, proto_err, illegal_err and out_valid are low. From the second cycle after reset onward, in_ready stays high.
- R2: While in S_HUNT, any character other than 0x02 is dropped. It is not summed and not forwarded.
- R3: sum_out is the 16-bit wrapping sum of the character codes from the 0x02 that opened the frame through the 0x03 that closed it, both included. Line feed 0x0A and carriage return 0x0D are summed like any other code.
- R4: Each character accepted in S_BODY that is neither 0x02 nor 0x03 appears on out_data, with out_valid high, in the cycle after it is accepted. The framing codes themselves are never forwarded.
- R5: The four characters after 0x03 are read as hex digits, most significant first. The digit set is 0x30-0x39, 0x41-0x46 and 0x61-0x66. When the fourth digit is accepted, done pulses for one cycle, and match is high only if the digits equal sum_out.
- R6: A character other than a hex digit in any of the four digit positions ends the check at once. done and fmt_err pulse together, match stays low, and the block returns to S_HUNT.
- R7: The legal codes are 0x20-0x7E, 0x02, 0x03, 0x0A and 0x0D. Any other accepted code pulses illegal_err in the next cycle, in every state. Inside a frame it is still summed and forwarded.
- R8: A 0x02 accepted in S_BODY pulses proto_err in the next cycle and restarts the sum at 0x0002.
- R9: After done, characters are dropped until a new 0x02 arrives.
- R10: A cycle with in_valid low changes neither the state nor the sum, whatever in_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input character is valid |
| in_data | input | 8 | Input character code |
| in_ready | output | 1 | Block can accept a character |
| out_valid | output | 1 | Forwarded frame character is valid |
| out_data | output | 8 | Forwarded frame character |
| done | output | 1 | One-cycle pulse when the check ends |
| match | output | 1 | With done: the received digits equal the sum |
| fmt_err | output | 1 | With done: a check position held a character that is not a hex digit |
| proto_err | output | 1 | Pulse: start code seen inside an open frame |
| illegal_err | output | 1 | Pulse: the previous accepted code was illegal |
| sum_out | output | 16 | Running frame sum; final when done pulses |

## Verification
The bench targets these corner cases:
- Lowercase check digits. A design that accepts only uppercase would report a format error on a correct frame.
- A long frame that forces the 16-bit sum to wrap. A design that saturates the sum, or leaves out the framing codes, would flag a mismatch on a correct frame.
- A start code repeated inside a frame. A design that keeps the old partial sum would mismatch.
- A non-hex character in a digit position. A design that skips it would keep waiting for digits.
- Characters before the start code, after done, and on cycles with in_valid low. A design that leaks them into the sum would produce a wrong sum_out.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    localparam logic [7:0] CODE_START = 8'h02;
    localparam logic [7:0] CODE_END   = 8'h03;
    localparam logic [7:0] CODE_LF    = 8'h0A;
    localparam logic [7:0] CODE_CR    = 8'h0D;
    localparam logic [7:0] PRINT_LO   = 8'h20;
    localparam logic [7:0] PRINT_HI   = 8'h7E;

    typedef enum logic [1:0] {
        S_HUNT   = 2'd0,
        S_BODY   = 2'd1,
        S_DIGITS = 2'd2
    } chk_state_t;
endpackage

// File: rtl/fsc_char_class.sv
module fsc_char_class
    import fsc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] ch,
    output logic              is_start,
    output logic              is_end,
    output logic              is_legal,
    output logic              is_hex,
    output logic [3:0]        hex_val
);
    logic in_print, is_dec, is_upper, is_lower;

    always_comb begin
        is_start = (ch == DATA_W'(CODE_START));
        is_end   = (ch == DATA_W'(CODE_END));
        in_print = (ch >= DATA_W'(PRINT_LO)) && (ch <= DATA_W'(PRINT_HI));
        is_legal = in_print || is_start || is_end
                 || (ch == DATA_W'(CODE_LF)) || (ch == DATA_W'(CODE_CR));
        is_dec   = (ch >= DATA_W'(8'h30)) && (ch <= DATA_W'(8'h39));
        is_upper = (ch >= DATA_W'(8'h41)) && (ch <= DATA_W'(8'h46));
        is_lower = (ch >= DATA_W'(8'h61)) && (ch <= DATA_W'(8'h66));
        is_hex   = is_dec || is_upper || is_lower;
        if (is_dec) hex_val = ch[3:0];
        else        hex_val = 4'(ch[3:0] + 4'd9);
    end

    always_comb begin
        AST_HEX_IS_LEGAL: assert (!(is_hex && !is_legal)); // R7
    end
endmodule

// File: rtl/fsc_sum_accum.sv
module fsc_sum_accum
    import fsc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SUM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_start,
    input  logic              add_en,
    input  logic [DATA_W-1:0] add_val,
    output logic [SUM_W-1:0]  sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sum <= '0;
        else if (load_start) sum <= SUM_W'(CODE_START);
        else if (add_en)     sum <= sum + SUM_W'(add_val);
    end

    AST_SUM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_start) |-> (sum == SUM_W'(CODE_START))); // R8
    AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_start) && !$past(add_en)) |-> $stable(sum)); // R10
endmodule

// File: rtl/fsc_hex_shift.sv
module fsc_hex_shift #(
    parameter int SUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic [3:0]       nibble,
    output logic [SUM_W-1:0] value_next
);
    logic [SUM_W-1:0] value;

    assign value_next = {value[SUM_W-5:0], nibble};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        value <= '0;
        else if (clr)      value <= '0;
        else if (shift_en) value <= value_next;
    end

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (value == '0)); // R5
endmodule

// File: rtl/frame_sum_checker.sv
module frame_sum_checker
    import fsc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SUM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              done,
    output logic              match,
    output logic              fmt_err,
    output logic              proto_err,
    output logic              illegal_err,
    output logic [SUM_W-1:0]  sum_out
);
    localparam int NDIG  = SUM_W / 4;
    localparam int CNT_W = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam logic [CNT_W-1:0] LAST_DIG = CNT_W'(NDIG - 1);

    chk_state_t state, state_nx;
    logic acc;
    logic is_start, is_end, is_legal, is_hex;
    logic [3:0] hex_val;
    logic sum_load, sum_add, hex_clr, hex_shift;
    logic [SUM_W-1:0] exp_next;
    logic [CNT_W-1:0] dig_cnt;

    assign acc = in_valid && in_ready;

    fsc_char_class #(.DATA_W(DATA_W)) u_class (
        .ch(in_data), .is_start(is_start), .is_end(is_end),
        .is_legal(is_legal), .is_hex(is_hex), .hex_val(hex_val)
    );

    fsc_sum_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .load_start(sum_load), .add_en(sum_add),
        .add_val(in_data), .sum(sum_out)
    );

    fsc_hex_shift #(.SUM_W(SUM_W)) u_hex (
        .clk(clk), .rst_n(rst_n), .clr(hex_clr), .shift_en(hex_shift),
        .nibble(hex_val), .value_next(exp_next)
    );

    // control strobes to the datapath
    always_comb begin
        sum_load  = acc && is_start && (state != S_DIGITS);
        sum_add   = acc && (state == S_BODY) && !is_start;
        hex_clr   = acc && (state == S_BODY) && is_end;
        hex_shift = acc && (state == S_DIGITS) && is_hex;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_HUNT:   if (acc && is_start) state_nx = S_BODY;
            S_BODY:   if (acc && is_end)   state_nx = S_DIGITS;
            S_DIGITS: if (acc && (!is_hex || dig_cnt == LAST_DIG)) state_nx = S_HUNT;
            default:  state_nx = S_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_HUNT;
        else        state <= state_nx;
    end

    // digit position counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         dig_cnt <= '0;
        else if (hex_clr)   dig_cnt <= '0;
        else if (hex_shift) dig_cnt <= dig_cnt + 1'b1;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_ready    <= 1'b0;
            out_valid   <= 1'b0;
            out_data    <= '0;
            done        <= 1'b0;
            match       <= 1'b0;
            fmt_err     <= 1'b0;
            proto_err   <= 1'b0;
            illegal_err <= 1'b0;
        end else begin
            in_ready    <= 1'b1;
            out_valid   <= 1'b0;
            done        <= 1'b0;
            match       <= 1'b0;
            fmt_err     <= 1'b0;
            proto_err   <= 1'b0;
            illegal_err <= acc && !is_legal;
            if (acc) begin
                unique case (state)
                    S_HUNT: ;
                    S_BODY: begin
                        if (is_start) begin
                            proto_err <= 1'b1;
                        end else if (!is_end) begin
                            out_valid <= 1'b1;
                            out_data  <= in_data;
                        end
                    end
                    S_DIGITS: begin
                        if (!is_hex) begin
                            done    <= 1'b1;
                            fmt_err <= 1'b1;
                        end else if (dig_cnt == LAST_DIG) begin
                            done  <= 1'b1;
                            match <= (exp_next == sum_out);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_FMT_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> (done && !match)); // R6
    AST_FWD_NO_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data != DATA_W'(CODE_START) && out_data != DATA_W'(CODE_END))); // R4
    AST_ILLEGAL_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_err |-> $past(in_valid)); // R7
    AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_ready) |-> in_ready); // R1
    AST_HUNT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state == S_HUNT)); // R9
endmodule

// File: tb/sim_frame_sum_checker.sv
module sim_frame_sum_checker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, out_valid, done, match, fmt_err, proto_err, illegal_err;
    logic [7:0] out_data;
    logic [15:0] sum_out;
    int checks = 0;
    int failures = 0;
    logic [15:0] esum;

    always #10 clk = ~clk;

    frame_sum_checker u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .done(done), .match(match), .fmt_err(fmt_err), .proto_err(proto_err),
        .illegal_err(illegal_err), .sum_out(sum_out)
    );

    // {char, done, match, fmt, proto, illegal, out_valid}
    localparam int NV = 18;
    localparam logic [13:0] TBL [0:NV-1] = '{
        {8'h41, 6'b000000}, {8'h02, 6'b000000}, {8'h41, 6'b000001},
        {8'h42, 6'b000001}, {8'h0D, 6'b000001}, {8'h0A, 6'b000001},
        {8'h03, 6'b000000}, {8'h30, 6'b000000}, {8'h30, 6'b000000},
        {8'h39, 6'b000000}, {8'h46, 6'b110000}, {8'h02, 6'b000000},
        {8'h31, 6'b000001}, {8'h03, 6'b000000}, {8'h30, 6'b000000},
        {8'h30, 6'b000000}, {8'h33, 6'b000000}, {8'h37, 6'b100000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [7:0] hexch(input logic [3:0] n, input bit lower);
        if (n < 4'd10) return 8'h30 + {4'd0, n};
        return (lower ? 8'h57 : 8'h37) + {4'd0, n};
    endfunction

    task automatic send_digits(input logic [15:0] v, input bit lower);
        for (int i = 3; i >= 0; i--) send(hexch(v[i*4 +: 4], lower));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 done in reset", {31'd0, done}, 0);
        check("R1 flags in reset", {26'd0, match, fmt_err, proto_err, illegal_err, out_valid, 1'b0}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 ready after reset", {31'd0, in_ready}, 1);

        // table walk: R2 R3 R4 R5
        for (int k = 0; k < NV; k++) begin
            send(TBL[k][13:6]);
            check("R5 done/match table", {30'd0, done, match}, {30'd0, TBL[k][5:4]});
            check("R8 R6 R7 flags table", {29'd0, fmt_err, proto_err, illegal_err},
                  {29'd0, TBL[k][3:1]});
            check("R4 forward table", {31'd0, out_valid}, {31'd0, TBL[k][0]});
            if (TBL[k][0]) check("R4 forward data", {24'd0, out_data}, {24'd0, TBL[k][13:6]});
        end
        check("R3 sum of second frame", {16'd0, sum_out}, 32'h36);

        // R10: in_valid low is ignored, then R9/R2 non-start dropped
        @(negedge clk);
        in_data = 8'h02;
        @(negedge clk);
        send(8'h35);
        check("R10 R2 no forward in hunt", {31'd0, out_valid}, 0);
        check("R10 sum unchanged", {16'd0, sum_out}, 32'h36);

        // R7: illegal in hunt
        send(8'h80);
        check("R7 illegal in hunt", {31'd0, illegal_err}, 1);
        check("R2 illegal not summed", {16'd0, sum_out}, 32'h36);

        // R8: restart on repeated start
        send(8'h02); send(8'h41);
        send(8'h02);
        check("R8 proto flag", {31'd0, proto_err}, 1);
        check("R8 sum restarted", {16'd0, sum_out}, 32'h02);
        send(8'h42); send(8'h03);
        send_digits(16'h0047, 1'b0);
        check("R8 restarted frame matches", {30'd0, done, match}, 3);

        // R5: lowercase digits
        send(8'h02); send(8'h7E); send(8'h20); send(8'h03);
        send_digits(16'h00A3, 1'b1);
        check("R5 lowercase match", {30'd0, done, match}, 3);

        // R7: illegal inside frame summed and forwarded
        send(8'h02); send(8'h01);
        check("R7 illegal in frame flagged", {31'd0, illegal_err}, 1);
        check("R7 illegal in frame forwarded", {31'd0, out_valid}, 1);
        send(8'h03);
        send_digits(16'h0006, 1'b0);
        check("R7 illegal summed", {30'd0, done, match}, 3);

        // R3: wraparound with long frame
        esum = 16'h0002;
        send(8'h02);
        for (int i = 0; i < 600; i++) begin
            send(8'h7E);
            esum = esum + 16'h7E;
        end
        send(8'h0D); esum = esum + 16'h0D;
        send(8'h03); esum = esum + 16'h03;
        check("R3 wrapped sum", {16'd0, sum_out}, {16'd0, esum});
        send_digits(esum, 1'b0);
        check("R3 wrapped match", {30'd0, done, match}, 3);

        // R6: format error, then R9 drop
        send(8'h02); send(8'h03); send(8'h30);
        send(8'h47);
        check("R6 fmt done", {29'd0, done, match, fmt_err}, 32'b101);
        check("R3 empty frame sum", {16'd0, sum_out}, 5);
        send(8'h31);
        check("R9 dropped after done", {30'd0, out_valid, done}, 0);
        check("R9 sum kept", {16'd0, sum_out}, 5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule